// File: doc/BRIEF.md
# Nibble-Wide DRAM Access Sequencer

This block drives a dynamic RAM array whose data path is four bits wide. It turns each 500 ns memory slot, eight ticks of a 16 MHz clock, into one byte transfer. Each transfer is a single row cycle that holds two page-mode column accesses. The first column access moves the low half of the byte and the second moves the high half. The sequencer puts out the row strobe, the column strobe, the write enable and the multiplexed 8-bit address. It also drives the write nibble and captures the read nibbles.

Two requesters share the slots. One is a CPU port and the other is a video-fetch port, which always reads. While the video fetch window is open in a half-bandwidth display mode, video takes every even-numbered slot and the CPU may use the odd ones, so the CPU runs at an effective 1 MHz. In a full-bandwidth mode the video port takes every slot during the window. Outside the window the CPU may have every slot. The block returns the assembled byte with a one-tick valid pulse to whichever port owned the slot. It also gives the CPU a clock enable at the end of every slot that video did not own.

The controller is an eight-state cycle: ST_ROW → ST_RAS → ST_COL_A → ST_CAS_A → ST_COL_B → ST_CAS_B → ST_PRE → ST_DONE → ST_ROW. It advances one state per tick. Reset, at any point, forces ST_ROW with no owner. The owner and address of the next slot are sampled on the tick that leaves ST_DONE. Slot 0, which follows reset, is always idle and counts as even.

Top module: `dram_slot_seq`

## Requirements
- R1: A slot is eight ticks, numbered 0 to 7 from ST_ROW. In a slot that has an owner, ram_ras_n is low in ticks 1–5 and ram_cas_n is low only in ticks 3 and 5. Both strobes stay high in an idle slot.
- R2: The slot address A is 15 bits. ram_a carries A[14:7] in ticks 0–1, {A[6:0],0} in ticks 2–3 and {A[6:0],1} in ticks 4–5. Each value is therefore stable for a tick before the strobe that latches it falls.
- R3: ram_cas_n is never low while ram_ras_n is high.
- R4: For a read, the nibble captured in tick 3 becomes rd_data[3:0] and the nibble captured in tick 5 becomes rd_data[7:4]. The owner's valid output (cpu_rd_valid or vid_rd_valid) pulses only in tick 7, and the two valids are never high together.
- R5: In a CPU write slot, ram_we_n is low and ram_dq_oe is high in ticks 2–5. ram_dq_out carries wdata[3:0] in ticks 2–3 and wdata[7:4] in ticks 4–5. A write slot gives no read valid. In every other slot ram_we_n stays high and ram_dq_oe stays low.
- R6: If fetch_active and full_bw are high when a slot starts, video owns that slot whatever the CPU request.
- R7: If fetch_active is high and full_bw is low, video owns the even-numbered slots. In the odd-numbered slots the CPU owns the slot if cpu_req is high, and otherwise the slot is idle.
- R8: If fetch_active is low, the CPU owns the slot when cpu_req is high, and otherwise the slot is idle.
- R9: cpu_clk_en is high only in tick 7, and only in a slot that video did not own.
- R10: Reset, even in the middle of a slot, drives both strobes and ram_we_n high, ram_dq_oe low and both valids and cpu_clk_en low at once. The first slot after reset is idle, even if a CPU request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_active | input | 1 | Video fetch window open |
| full_bw | input | 1 | 1 = video owns every slot in the window, 0 = alternate slots |
| cpu_req | input | 1 | CPU wants the next slot |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 15 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| vid_addr | input | 15 | Video fetch byte address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_a | output | 8 | Multiplexed row/column address |
| ram_dq_out | output | 4 | Write nibble |
| ram_dq_oe | output | 1 | Write nibble drive enable |
| ram_dq_in | input | 4 | Read nibble from the RAM |
| rd_data | output | 8 | Assembled read byte |
| cpu_rd_valid | output | 1 | CPU read byte ready |
| vid_rd_valid | output | 1 | Video read byte ready |
| cpu_clk_en | output | 1 | CPU clock enable, one tick per non-video slot |

## Verification
The hardest case to reach is a reset in the middle of an active slot, followed by a first slot that must stay idle while a CPU request is pending. The stimulus aligns on the slot tick count. It waits until the column strobe of a CPU slot is low, then pulls reset and checks the strobes at once. It then releases reset with cpu_req held high and watches the whole slot. The even/odd interleave is also only visible through slot numbering counted from reset, so the vector table is ordered so that each row lands on a known slot parity.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [2:0] {
        ST_ROW, ST_RAS, ST_COL_A, ST_CAS_A, ST_COL_B, ST_CAS_B, ST_PRE, ST_DONE
    } phase_e;

    typedef enum logic [1:0] {
        OWN_IDLE, OWN_CPU, OWN_VID
    } owner_e;
endpackage

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter
    import dram_seq_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_end,
    input  logic          fetch_active,
    input  logic          full_bw,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] vid_addr,
    output owner_e        owner,
    output logic          slot_we,
    output logic [AW-1:0] slot_addr
);
    logic   odd_q;
    logic   vid_take;
    owner_e nxt_owner;

    always_comb begin
        // next slot is even when the current one is odd
        vid_take = fetch_active && (full_bw || odd_q);
        if (vid_take)
            nxt_owner = OWN_VID;
        else if (cpu_req)
            nxt_owner = OWN_CPU;
        else
            nxt_owner = OWN_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q     <= 1'b0;
            owner     <= OWN_IDLE;
            slot_we   <= 1'b0;
            slot_addr <= '0;
        end else if (slot_end) begin
            odd_q     <= ~odd_q;
            owner     <= nxt_owner;
            slot_we   <= (nxt_owner == OWN_CPU) && cpu_we;
            slot_addr <= vid_take ? vid_addr : cpu_addr;
        end
    end

    // R7: in alternate mode video never takes two slots in a row
    assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && owner == OWN_VID && fetch_active && !full_bw) |=> (owner != OWN_VID));

    // R5: video slots never write
    assert_vid_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_VID) |-> !slot_we);
endmodule

// File: rtl/dram_nibble_path.sv
module dram_nibble_path #(
    parameter int DQ_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              ld_wdata,
    input  logic              sel_hi,
    input  logic [2*DQ_W-1:0] cpu_wdata,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic [2*DQ_W-1:0] rd_data
);
    logic [DQ_W-1:0]   lo_q;
    logic [2*DQ_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            rd_data <= '0;
            wdata_q <= '0;
        end else begin
            if (ld_wdata) wdata_q <= cpu_wdata;
            if (cap_lo)   lo_q    <= dq_in;
            if (cap_hi)   rd_data <= {dq_in, lo_q};
        end
    end

    assign dq_out = sel_hi ? wdata_q[2*DQ_W-1:DQ_W] : wdata_q[DQ_W-1:0];

    // R4: the high nibble is only taken two ticks after the low one
    assert_lo_before_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hi |-> $past(cap_lo, 2));
endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
    import dram_seq_pkg::*;
#(
    parameter int RA_W = 8,
    parameter int DQ_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_active,
    input  logic                full_bw,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [2*RA_W-2:0]   cpu_addr,
    input  logic [2*DQ_W-1:0]   cpu_wdata,
    input  logic [2*RA_W-2:0]   vid_addr,
    output logic                ram_ras_n,
    output logic                ram_cas_n,
    output logic                ram_we_n,
    output logic [RA_W-1:0]     ram_a,
    output logic [DQ_W-1:0]     ram_dq_out,
    output logic                ram_dq_oe,
    input  logic [DQ_W-1:0]     ram_dq_in,
    output logic [2*DQ_W-1:0]   rd_data,
    output logic                cpu_rd_valid,
    output logic                vid_rd_valid,
    output logic                cpu_clk_en
);
    localparam int AW = 2*RA_W - 1;

    phase_e          state, nxt_state;
    owner_e          owner;
    logic            slot_we;
    logic [AW-1:0]   slot_addr;
    logic            active, rd_slot, wr_slot;
    logic            cap_lo, cap_hi, sel_hi;
    logic [RA_W-1:0] row_a, col_a, col_b;

    assign active  = (owner != OWN_IDLE);
    assign wr_slot = active && slot_we;
    assign rd_slot = active && !slot_we;
    assign row_a   = slot_addr[AW-1:RA_W-1];
    assign col_a   = {slot_addr[RA_W-2:0], 1'b0};
    assign col_b   = {slot_addr[RA_W-2:0], 1'b1};

    dram_slot_arbiter #(.AW(AW)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_end     (state == ST_DONE),
        .fetch_active (fetch_active),
        .full_bw      (full_bw),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .vid_addr     (vid_addr),
        .owner        (owner),
        .slot_we      (slot_we),
        .slot_addr    (slot_addr)
    );

    dram_nibble_path #(.DQ_W(DQ_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .ld_wdata  (state == ST_DONE),
        .sel_hi    (sel_hi),
        .cpu_wdata (cpu_wdata),
        .dq_in     (ram_dq_in),
        .dq_out    (ram_dq_out),
        .rd_data   (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ROW;
        else        state <= nxt_state;
    end

    always_comb begin
        unique case (state)
            ST_ROW:   nxt_state = ST_RAS;
            ST_RAS:   nxt_state = ST_COL_A;
            ST_COL_A: nxt_state = ST_CAS_A;
            ST_CAS_A: nxt_state = ST_COL_B;
            ST_COL_B: nxt_state = ST_CAS_B;
            ST_CAS_B: nxt_state = ST_PRE;
            ST_PRE:   nxt_state = ST_DONE;
            ST_DONE:  nxt_state = ST_ROW;
            default:  nxt_state = ST_ROW;
        endcase
    end

    // outputs
    always_comb begin
        ram_ras_n    = 1'b1;
        ram_cas_n    = 1'b1;
        ram_we_n     = 1'b1;
        ram_dq_oe    = 1'b0;
        ram_a        = row_a;
        sel_hi       = 1'b0;
        cap_lo       = 1'b0;
        cap_hi       = 1'b0;
        cpu_rd_valid = 1'b0;
        vid_rd_valid = 1'b0;
        cpu_clk_en   = 1'b0;
        unique case (state)
            ST_ROW: ram_a = row_a;
            ST_RAS: begin
                ram_ras_n = !active;
                ram_a     = row_a;
            end
            ST_COL_A: begin
                ram_ras_n = !active;
                ram_a     = col_a;
                ram_we_n  = !wr_slot;
                ram_dq_oe = wr_slot;
            end
            ST_CAS_A: begin
                ram_ras_n = !active;
                ram_cas_n = !active;
                ram_a     = col_a;
                ram_we_n  = !wr_slot;
                ram_dq_oe = wr_slot;
                cap_lo    = rd_slot;
            end
            ST_COL_B: begin
                ram_ras_n = !active;
                ram_a     = col_b;
                ram_we_n  = !wr_slot;
                ram_dq_oe = wr_slot;
                sel_hi    = 1'b1;
            end
            ST_CAS_B: begin
                ram_ras_n = !active;
                ram_cas_n = !active;
                ram_a     = col_b;
                ram_we_n  = !wr_slot;
                ram_dq_oe = wr_slot;
                sel_hi    = 1'b1;
                cap_hi    = rd_slot;
            end
            ST_PRE: ram_a = col_b;
            ST_DONE: begin
                ram_a        = col_b;
                cpu_rd_valid = rd_slot && (owner == OWN_CPU);
                vid_rd_valid = (owner == OWN_VID);
                cpu_clk_en   = (owner != OWN_VID);
            end
            default: ram_a = row_a;
        endcase
    end

    assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cas_n |-> !ram_ras_n);

    assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ras_n) |-> $stable(ram_a));

    assert_col_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_cas_n) |-> $stable(ram_a));

    assert_we_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cas_n |-> $stable(ram_we_n));

    assert_valid_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rd_valid, vid_rd_valid}));

    assert_no_en_in_video_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vid_rd_valid |-> !cpu_clk_en);
endmodule

// File: tb/dram_slot_seq_bench.sv
`timescale 1ns/1ps
module dram_slot_seq_bench;
    localparam int CLK_PERIOD = 62;

    typedef struct packed {
        logic        fetch;
        logic        full;
        logic        req;
        logic        we;
        logic [14:0] caddr;
        logic [7:0]  wdata;
        logic [14:0] vaddr;
        logic [1:0]  own;   // 0 idle, 1 cpu, 2 video
    } vec_t;

    // row i is slot i+1 after reset; even slots go to video in alternate mode
    localparam vec_t VEC [0:12] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 15'h1234, 8'h00, 15'h0100, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 15'h0AAA, 8'h00, 15'h2A5C, 2'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 15'h7F01, 8'hC3, 15'h0200, 2'd1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 15'h1111, 8'h00, 15'h3456, 2'd2},
        '{1'b1, 1'b1, 1'b1, 1'b0, 15'h2222, 8'h00, 15'h0777, 2'd2},
        '{1'b0, 1'b1, 1'b1, 1'b0, 15'h4000, 8'h00, 15'h0000, 2'd1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 15'h5555, 8'h00, 15'h0000, 2'd0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h7FFF, 8'h00, 15'h0000, 2'd1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 15'h0000, 8'h00, 15'h1357, 2'd0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 15'h0000, 8'h00, 15'h0000, 2'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 15'h0081, 8'h5A, 15'h6000, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h3C3C, 8'h96, 15'h0000, 2'd1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, 8'h00, 15'h7FFF, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_active = 1'b0, full_bw = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
    logic [14:0] cpu_addr = '0, vid_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe;
    logic [7:0]  ram_a, rd_data;
    logic [3:0]  ram_dq_out, ram_dq_in;
    logic        cpu_rd_valid, vid_rd_valid, cpu_clk_en;
    logic [7:0]  row_l = '0;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_slot_seq u_dram_slot_seq (
        .clk(clk), .rst_n(rst_n), .fetch_active(fetch_active), .full_bw(full_bw),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .vid_addr(vid_addr), .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n),
        .ram_we_n(ram_we_n), .ram_a(ram_a), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in), .rd_data(rd_data), .cpu_rd_valid(cpu_rd_valid),
        .vid_rd_valid(vid_rd_valid), .cpu_clk_en(cpu_clk_en)
    );

    // RAM model: row taken on the row strobe fall, nibble is a function of row and column
    function automatic logic [3:0] nib(input logic [7:0] r, input logic [7:0] c);
        return r[3:0] ^ r[7:4] ^ c[3:0] ^ {c[7:5], 1'b0} ^ (c[0] ? 4'h6 : 4'h0);
    endfunction

    always @(negedge ram_ras_n) row_l = ram_a;
    assign ram_dq_in = nib(row_l, ram_a);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        fetch_active = v.fetch;
        full_bw      = v.full;
        cpu_req      = v.req;
        cpu_we       = v.we;
        cpu_addr     = v.caddr;
        cpu_wdata    = v.wdata;
        vid_addr     = v.vaddr;
    endtask

    // entered at the negedge of tick 7 of the previous slot
    task automatic run_slot(input vec_t v);
        logic [14:0] a;
        bit          act, wr;
        string       otag;
        drive(v);
        a    = (v.own == 2'd2) ? v.vaddr : v.caddr;
        act  = (v.own != 2'd0);
        wr   = (v.own == 2'd1) && v.we;
        otag = (v.own == 2'd2 && v.full) ? "R6" : (v.fetch ? "R7" : "R8");
        for (int p = 0; p < 8; p++) begin
            logic       e_ras, e_cas, e_we, e_oe, e_cv, e_vv, e_en;
            logic [7:0] e_a;
            @(negedge clk);
            e_ras = !(act && p >= 1 && p <= 5);
            e_cas = !(act && (p == 3 || p == 5));
            e_we  = !(wr && p >= 2 && p <= 5);
            e_oe  = wr && p >= 2 && p <= 5;
            e_cv  = (p == 7) && (v.own == 2'd1) && !v.we;
            e_vv  = (p == 7) && (v.own == 2'd2);
            e_en  = (p == 7) && (v.own != 2'd2);
            e_a   = (p < 2) ? a[14:7] : (p < 4) ? {a[6:0], 1'b0} : {a[6:0], 1'b1};
            chk({ram_ras_n, ram_cas_n} == {e_ras, e_cas}, "R1", "strobes",
                {ram_ras_n, ram_cas_n}, {e_ras, e_cas});
            chk(ram_cas_n || !ram_ras_n, "R3", "cas inside ras", {ram_ras_n, ram_cas_n}, 2'b00);
            if (act && p <= 5)
                chk(ram_a == e_a, "R2", "ram_a", ram_a, e_a);
            chk({ram_we_n, ram_dq_oe} == {e_we, e_oe}, "R5", "we/oe",
                {ram_we_n, ram_dq_oe}, {e_we, e_oe});
            if (e_oe)
                chk(ram_dq_out == ((p < 4) ? v.wdata[3:0] : v.wdata[7:4]), "R5", "dq_out",
                    ram_dq_out, (p < 4) ? v.wdata[3:0] : v.wdata[7:4]);
            chk({cpu_rd_valid, vid_rd_valid} == {e_cv, e_vv}, otag, "owner valids",
                {cpu_rd_valid, vid_rd_valid}, {e_cv, e_vv});
            chk(cpu_clk_en == e_en, "R9", "cpu_clk_en", cpu_clk_en, e_en);
            if (p == 7 && act && !wr) begin
                logic [7:0] e_d;
                e_d = {nib(a[14:7], {a[6:0], 1'b1}), nib(a[14:7], {a[6:0], 1'b0})};
                chk(rd_data == e_d, "R4", "rd_data", rd_data, e_d);
            end
        end
    endtask

    // slot 0 after reset: entered at the release negedge (tick 0)
    task automatic idle_slot0();
        for (int p = 0; p < 8; p++) begin
            if (p > 0) @(negedge clk);
            chk(ram_ras_n && ram_cas_n && ram_we_n && !ram_dq_oe, "R10", "slot0 idle",
                {ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe}, 4'b1110);
            chk(cpu_clk_en == (p == 7), "R9", "slot0 enable", cpu_clk_en, (p == 7));
        end
    endtask

    task automatic reset_state_check();
        chk({ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe} == 4'b1110, "R10", "reset strobes",
            {ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe}, 4'b1110);
        chk({cpu_rd_valid, vid_rd_valid, cpu_clk_en} == 3'b000, "R10", "reset valids",
            {cpu_rd_valid, vid_rd_valid, cpu_clk_en}, 3'b000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t rv;
        repeat (3) @(negedge clk);
        reset_state_check();
        cpu_req = 1'b1;
        rst_n   = 1'b1;
        idle_slot0();
        for (int i = 0; i < 13; i++) run_slot(VEC[i]);

        // corner: reset in the middle of a CPU read slot
        rv = '{1'b0, 1'b0, 1'b1, 1'b0, 15'h2468, 8'h00, 15'h0000, 2'd1};
        drive(rv);
        repeat (4) @(negedge clk);
        chk(!ram_cas_n, "R1", "cas low before mid-slot reset", ram_cas_n, 1'b0);
        rst_n = 1'b0;
        #1;
        reset_state_check();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle_slot0();
        run_slot(rv);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule